// File: doc/BRIEF.md
# Indexed Extended Register Port

This block gives a host on a simple byte-oriented I/O bus access to a bank of 8-bit configuration registers through two adjacent port addresses. The host first writes a register number to the index port, then either writes a value to or reads a value from the data port one address above it. The index port address is chosen by a strap input that selects one of two fixed locations. A single 16-bit write to the index port, with the register number in the low byte and the value in the high byte, updates a register in one bus access.

Each index write is good for exactly one data-port access. The access consumes it, so a second data write issued without a new index is dropped. The bank holds 16, 32 or 64 registers, chosen by a parameter. The bank always ends at index 0xBF, so the top sixteen registers sit at 0xB0 to 0xBF in every configuration. Every register is also presented on a flat parallel output so that neighbouring logic can use the configuration bits directly.

Top module: `xreg_port`

## Requirements
- R1: With `base_sel` low the index port is at 0x01CE, and with it high it is at 0x03CE. The data port is always the index port plus one. Accesses to any other address change no register, no output and no armed index.
- R2: A byte write (`io_wide` low) to the index port stores `io_wdata[7:0]` as the current index and arms it, replacing any earlier index.
- R3: A byte write to the data port with an armed, in-range index loads `io_wdata[7:0]` into that register. The new value appears on `bank_q` from the next clock cycle.
- R4: A read strobe on the data port with an armed, in-range index drives that register's value on `io_rdata` combinationally during the strobe cycle.
- R5: Any byte write or read at the data port disarms the index at the end of that cycle. A second data write without a fresh index changes nothing.
- R6: A write with `io_wide` high to the index port loads `io_wdata[15:8]` into the register indexed by `io_wdata[7:0]` in that single access, and leaves the index disarmed.
- R7: With N = `NUM_REGS` registers, index 0xC0-N+k maps to register k, which appears on `bank_q[8k+7:8k]`. Index 0xBF is always register N-1, and indices 0xB0 to 0xBF are always the top sixteen registers.
- R8: A write to an index below 0xC0-N or above 0xBF changes no register. A read of such an index returns 0xFF.
- R9: `io_rdata` is 0xFF whenever no armed data read is in progress. A data read with no armed index returns 0xFF and changes no register.
- R10: A synchronous active-high reset clears every register to 0x00 and leaves the index disarmed.
- R11: A write with `io_wide` high to the data port is ignored: it changes no register and does not consume the armed index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_sel | input | 1 | Strap: 0 puts the index port at 0x01CE, 1 puts it at 0x03CE |
| io_addr | input | 16 | I/O port address |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access; wins over io_rd |
| io_wide | input | 1 | High byte lane enable for a 16-bit write |
| io_wdata | input | 16 | Write data; the low byte is used by byte writes |
| io_rdata | output | 8 | Read data, valid during the read strobe |
| bank_q | output | 8*NUM_REGS | All registers, register k in byte k |

## Verification
The bench targets the one-shot index rule. It issues a second data write and a second data read after a single index write. A design that kept the index armed would overwrite the register or return its value instead of 0xFF. It also checks that a combined 16-bit write leaves the index disarmed, and that a 16-bit write to the data port neither writes nor consumes the index. Both of these catch decoders that merge the byte lanes wrongly. Indices just outside the bank (0x7F and 0xC0) and both strap settings are covered. An off-by-one bound check or a fixed base address would write a neighbouring register or answer at the wrong port.

// File: rtl/xreg_pkg.sv
package xreg_pkg;

    localparam logic [15:0] PORT_A_BASE = 16'h01CE;
    localparam logic [15:0] PORT_B_BASE = 16'h03CE;
    localparam logic [7:0]  LAST_INDEX  = 8'hBF;
    localparam logic [7:0]  IDLE_BYTE   = 8'hFF;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_INDEX   = 3'd1,
        OP_PAIR    = 3'd2,
        OP_DATA_WR = 3'd3,
        OP_DATA_RD = 3'd4
    } port_op_e;

    typedef struct packed {
        port_op_e   op;
        logic [7:0] low;
        logic [7:0] high;
    } port_req_t;

    function automatic logic [15:0] index_port_addr(input logic sel);
        return sel ? PORT_B_BASE : PORT_A_BASE;
    endfunction

    function automatic logic index_in_bank(input logic [7:0] idx,
                                           input logic [7:0] first);
        return (idx >= first) && (idx <= LAST_INDEX);
    endfunction

endpackage

// File: rtl/xreg_decode.sv
module xreg_decode
    import xreg_pkg::*;
(
    input  logic        base_sel,
    input  logic [15:0] io_addr,
    input  logic        io_rd,
    input  logic        io_wr,
    input  logic        io_wide,
    input  logic [15:0] io_wdata,
    output port_req_t   req
);
    logic [15:0] idx_addr;
    logic [15:0] dat_addr;

    always_comb begin
        idx_addr = index_port_addr(base_sel);
        dat_addr = idx_addr + 16'd1;
        req.op   = OP_NONE;
        req.low  = io_wdata[7:0];
        req.high = io_wdata[15:8];
        if (io_wr) begin
            if (io_addr == idx_addr) begin
                req.op = io_wide ? OP_PAIR : OP_INDEX;
            end else if (io_addr == dat_addr && !io_wide) begin
                req.op = OP_DATA_WR;
            end
        end else if (io_rd && io_addr == dat_addr) begin
            req.op = OP_DATA_RD;
        end
    end

    always_comb begin
        if (req.op == OP_PAIR || req.op == OP_INDEX)
            a_idx_hit_r1: assert (io_addr == idx_addr);
    end
endmodule

// File: rtl/xreg_index.sv
module xreg_index
    import xreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  port_req_t  req,
    output logic       armed,
    output logic [7:0] cur_idx
);
    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b0;
            cur_idx <= 8'h00;
        end else begin
            unique case (req.op)
                OP_INDEX: begin
                    armed   <= 1'b1;
                    cur_idx <= req.low;
                end
                OP_PAIR, OP_DATA_WR, OP_DATA_RD: armed <= 1'b0;
                default: ;
            endcase
        end
    end

    p_arm_on_index_r2: assert property (@(posedge clk) disable iff (rst)
        req.op == OP_INDEX |=> armed && cur_idx == $past(req.low));

    p_one_shot_r5: assert property (@(posedge clk) disable iff (rst)
        (req.op == OP_DATA_WR || req.op == OP_DATA_RD) |=> !armed);

    p_pair_disarms_r6: assert property (@(posedge clk) disable iff (rst)
        req.op == OP_PAIR |=> !armed);

    p_reset_disarm_r10: assert property (@(posedge clk)
        rst |=> !armed);
endmodule

// File: rtl/xreg_bank.sv
module xreg_bank
    import xreg_pkg::*;
#(
    parameter int NUM_REGS = 64
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [7:0]            w_idx,
    input  logic [7:0]            w_val,
    input  logic                  r_en,
    input  logic [7:0]            r_idx,
    output logic [7:0]            rdata,
    output logic [8*NUM_REGS-1:0] flat
);
    localparam int         SLOT_W    = $clog2(NUM_REGS);
    localparam logic [7:0] FIRST_IDX = 8'(192 - NUM_REGS);

    logic [7:0]        regs [NUM_REGS];
    logic              w_ok;
    logic              r_ok;
    logic [SLOT_W-1:0] w_slot;
    logic [SLOT_W-1:0] r_slot;

    always_comb begin
        w_ok   = index_in_bank(w_idx, FIRST_IDX);
        r_ok   = index_in_bank(r_idx, FIRST_IDX);
        w_slot = SLOT_W'(w_idx - FIRST_IDX);
        r_slot = SLOT_W'(r_idx - FIRST_IDX);
    end

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[k] <= 8'h00;
            else if (we && w_ok && w_slot == SLOT_W'(k))
                regs[k] <= w_val;
        end
        assign flat[8*k +: 8] = regs[k];
    end

    always_comb begin
        rdata = IDLE_BYTE;
        if (r_en && r_ok)
            rdata = regs[r_slot];
    end

    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> flat == '0);

    p_out_of_range_r8: assert property (@(posedge clk) disable iff (rst)
        (we && !w_ok) |=> $stable(flat));

    p_hold_no_write_r9: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(flat));

    p_bad_read_r8: assert property (@(posedge clk) disable iff (rst)
        (r_en && !r_ok) |-> rdata == IDLE_BYTE);
endmodule

// File: rtl/xreg_port.sv
module xreg_port
    import xreg_pkg::*;
#(
    parameter int NUM_REGS = 64
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  base_sel,
    input  logic [15:0]           io_addr,
    input  logic                  io_rd,
    input  logic                  io_wr,
    input  logic                  io_wide,
    input  logic [15:0]           io_wdata,
    output logic [7:0]            io_rdata,
    output logic [8*NUM_REGS-1:0] bank_q
);
    port_req_t  req;
    logic       armed;
    logic [7:0] cur_idx;
    logic       we;
    logic [7:0] w_idx;
    logic [7:0] w_val;
    logic       r_en;

    xreg_decode u_decode (
        .base_sel (base_sel),
        .io_addr  (io_addr),
        .io_rd    (io_rd),
        .io_wr    (io_wr),
        .io_wide  (io_wide),
        .io_wdata (io_wdata),
        .req      (req)
    );

    xreg_index u_index (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .armed   (armed),
        .cur_idx (cur_idx)
    );

    always_comb begin
        we    = (req.op == OP_PAIR) || (req.op == OP_DATA_WR && armed);
        w_idx = (req.op == OP_PAIR) ? req.low  : cur_idx;
        w_val = (req.op == OP_PAIR) ? req.high : req.low;
        r_en  = (req.op == OP_DATA_RD) && armed;
    end

    xreg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (we),
        .w_idx (w_idx),
        .w_val (w_val),
        .r_en  (r_en),
        .r_idx (cur_idx),
        .rdata (io_rdata),
        .flat  (bank_q)
    );

    p_foreign_addr_r1: assert property (@(posedge clk) disable iff (rst)
        req.op == OP_NONE |=> $stable(bank_q) && armed == $past(armed));

    p_unarmed_read_r9: assert property (@(posedge clk) disable iff (rst)
        (io_rd && !io_wr && !armed) |-> io_rdata == IDLE_BYTE);

    p_wide_data_keeps_r11: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_wide && io_addr == index_port_addr(base_sel) + 16'd1)
        |=> $stable(bank_q) && armed == $past(armed));
endmodule

// File: tb/sim_xreg_port.sv
module sim_xreg_port;
    localparam int N     = 64;
    localparam int FIRST = 192 - N;
    localparam int NV    = 22;

    // op: 0 byte write, 1 wide write, 2 read and expect, 3 check register at index
    localparam logic [41:0] VEC [NV] = '{
        {2'd0, 16'h01CE, 16'h00B0, 8'h00},
        {2'd0, 16'h01CF, 16'h005A, 8'h00},
        {2'd3, 16'h00B0, 16'h0000, 8'h5A},  // R3 R7
        {2'd0, 16'h01CF, 16'h0033, 8'h00},
        {2'd3, 16'h00B0, 16'h0000, 8'h5A},  // R5 second write dropped
        {2'd0, 16'h01CE, 16'h00B0, 8'h00},
        {2'd2, 16'h01CF, 16'h0000, 8'h5A},  // R4
        {2'd2, 16'h01CF, 16'h0000, 8'hFF},  // R5 R9 consumed
        {2'd1, 16'h01CE, 16'hC380, 8'h00},
        {2'd3, 16'h0080, 16'h0000, 8'hC3},  // R6 R7 lowest index
        {2'd2, 16'h01CF, 16'h0000, 8'hFF},  // R6 disarmed
        {2'd0, 16'h01CE, 16'h007F, 8'h00},
        {2'd2, 16'h01CF, 16'h0000, 8'hFF},  // R8 below bank
        {2'd0, 16'h01CE, 16'h00BF, 8'h00},
        {2'd0, 16'h01CF, 16'h0099, 8'h00},
        {2'd3, 16'h00BF, 16'h0000, 8'h99},  // R7 top index
        {2'd0, 16'h03CE, 16'h00B1, 8'h00},
        {2'd0, 16'h01CF, 16'h0044, 8'h00},
        {2'd3, 16'h00B1, 16'h0000, 8'h00},  // R1 wrong base ignored
        {2'd0, 16'h01CE, 16'h00B1, 8'h00},
        {2'd1, 16'h01CF, 16'h7744, 8'h00},
        {2'd3, 16'h00B1, 16'h0000, 8'h00}   // R11 wide data write ignored
    };

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           base_sel = 1'b0;
    logic [15:0]    io_addr = 16'h0;
    logic           io_rd = 1'b0;
    logic           io_wr = 1'b0;
    logic           io_wide = 1'b0;
    logic [15:0]    io_wdata = 16'h0;
    logic [7:0]     io_rdata;
    logic [8*N-1:0] bank_q;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    xreg_port #(.NUM_REGS(N)) u0 (
        .clk(clk), .rst(rst), .base_sel(base_sel), .io_addr(io_addr),
        .io_rd(io_rd), .io_wr(io_wr), .io_wide(io_wide), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .bank_q(bank_q)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [15:0] d, input bit wide);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wide = wide; io_wr = 1'b1;
        @(posedge clk); #1;
        io_wr = 1'b0; io_wide = 1'b0;
    endtask

    task automatic bus_rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #5;
        check(io_rdata === exp, tag, io_rdata, exp);
        @(posedge clk); #1;
        io_rd = 1'b0;
    endtask

    task automatic reg_chk(input logic [7:0] idx, input logic [7:0] exp, input string tag);
        logic [7:0] v;
        @(negedge clk);
        v = bank_q[8*(int'(idx) - FIRST) +: 8];
        check(v === exp, tag, v, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R10 reset state
        @(negedge clk);
        check(bank_q == '0, "R10 bank cleared", bank_q[7:0], 8'h00);
        check(io_rdata === 8'hFF, "R9 idle rdata", io_rdata, 8'hFF);
        bus_rd(16'h01CF, 8'hFF, "R10 disarmed after reset");

        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [15:0] a;
            logic [15:0] d;
            logic [7:0]  e;
            {op, a, d, e} = VEC[i];
            case (op)
                2'd0: bus_wr(a, d, 1'b0);
                2'd1: bus_wr(a, d, 1'b1);
                2'd2: bus_rd(a, e, $sformatf("vector %0d R4/R5/R8/R9", i));
                default: reg_chk(a[7:0], e, $sformatf("vector %0d R3/R6/R7", i));
            endcase
        end

        // R11 index still armed after ignored wide data write
        bus_wr(16'h01CF, 16'h0066, 1'b0);
        reg_chk(8'hB1, 8'h66, "R11 index kept");

        // R8 write to index 0xC0 just above bank: nothing changes
        bus_wr(16'h01CE, 16'h00C0, 1'b0);
        bus_wr(16'h01CF, 16'h0022, 1'b0);
        reg_chk(8'hBF, 8'h99, "R8 top neighbour untouched");
        bus_wr(16'h01CE, 16'h00C0, 1'b0);
        bus_rd(16'h01CF, 8'hFF, "R8 read above bank");

        // R1 alternate base
        base_sel = 1'b1;
        bus_wr(16'h03CE, 16'h00A0, 1'b0);
        bus_wr(16'h03CF, 16'h0017, 1'b0);
        reg_chk(8'hA0, 8'h17, "R1 alternate base write");
        bus_wr(16'h03CE, 16'h00A0, 1'b0);
        bus_rd(16'h01CF, 8'hFF, "R1 old data port silent");
        bus_rd(16'h03CF, 8'h17, "R1 index survives foreign read");
        bus_wr(16'h03CE, 16'hE5B2, 1'b1);
        reg_chk(8'hB2, 8'hE5, "R6 pair at alternate base");

        // R9 unarmed read leaves state
        bus_rd(16'h03CF, 8'hFF, "R9 unarmed read");
        reg_chk(8'hB0, 8'h5A, "R9 register kept");

        // R10 reset clears written registers and disarms
        bus_wr(16'h03CE, 16'h00B0, 1'b0);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        reg_chk(8'hB0, 8'h00, "R10 register cleared");
        bus_rd(16'h03CF, 8'hFF, "R10 index disarmed");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 00 expected 01");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule